// File: doc/BRIEF.md
# Timer Compare-Match Output Unit

This block is one channel of a timer. It holds a free-running up-counter and a small bank of compare registers. Each compare register watches the counter. When the counter reaches the stored value, the register latches a status flag. It can also move its output pin, and it can fire a trigger toward a second timer channel. Only the lower-numbered compare registers own a pin. The rest still compare and flag, which lets software poll a match or take an interrupt at a chosen count with no pin activity.

Software programs the unit through a write-only register port. It sets the run bit, the counter value, each compare value, each register's pin action, the interrupt enables and the trigger routing. It clears flags by writing ones. The flags, the counter, the pins, one interrupt line and two trigger pulses (start and stop) are visible as ports. A pin can also be handed to a static software-driven level. Its compare register keeps flagging while the pin is held at that level.

Top module: `cmp_timer_unit`

## Requirements
- R1: After reset the counter is 0, all flags, pins, the interrupt and both trigger outputs are 0, every pin action is "keep", and every compare value is all ones.
- R2: Writing bit 0 of address 0 sets the run bit. While it is 1, the counter adds 1 on every clock edge. While it is 0, the counter holds. A write to address 4 loads the counter and takes priority over counting.
- R3: A match is a cycle in which the run bit is 1 and the counter equals compare register i (written at address 8+i). Flag i sets on the edge that ends that cycle.
- R4: Writing address 2 clears each flag whose data bit is 1. Bits written as 0 have no effect. A match in the same cycle as the clear keeps the flag set.
- R5: irq_o is 1 exactly while some flag is set and its enable bit (address 1, bit i) is 1.
- R6: The pin action of register i is held in bits [1:0] at address 16+i: 00 keep, 01 drive 0, 10 drive 1, 11 toggle. The pin changes on the same edge as the flag.
- R7: Compare registers with index NUM_PINS or above have no pin. They still set their flags and take part in the interrupt.
- R8: Bit 2 of a mode word gives the pin to software, and the pin then shows bit 3. The flag still sets on a match. The pin action still updates the hidden level, and that level shows again once bit 2 is cleared.
- R9: Address 3 routes the trigger. Bits [2:0] pick the source register, bit 4 enables the trigger and bit 5 picks stop (1) or start (0). Each match on the enabled source gives a one-cycle pulse on trig_start_o or trig_stop_o on the flag's edge. The two outputs are never high together, and a disabled trigger or a match on another register gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| count_o | output | CNT_W | Current counter value |
| flags_o | output | NUM_CMP | Match status flags |
| pins_o | output | NUM_PINS | Compare output pins |
| irq_o | output | 1 | Interrupt request |
| trig_start_o | output | 1 | Start trigger pulse to another channel |
| trig_stop_o | output | 1 | Stop trigger pulse to another channel |

## Verification
The risky overlap is a software flag clear and a hardware match that land on the same clock edge. The bench provokes it by reloading the counter two counts below the compare value, waiting until the counter sits on that value, and issuing the clear in that very cycle. It expects the flag to survive. A second clear one cycle later, with no match, must then succeed.

// File: rtl/ctu_pkg.sv
package ctu_pkg;

   typedef enum logic [1:0] {
      ACT_KEEP   = 2'b00,
      ACT_LOW    = 2'b01,
      ACT_HIGH   = 2'b10,
      ACT_TOGGLE = 2'b11
   } ctu_act_e;

   // mode word: [3] software level, [2] software owns pin, [1:0] action
   typedef struct packed {
      logic     sw_lvl;
      logic     sw_sel;
      ctu_act_e act;
   } ctu_mode_t;

   localparam int unsigned MODE_W      = 4;
   localparam int unsigned A_CTRL      = 0;
   localparam int unsigned A_IEN       = 1;
   localparam int unsigned A_CLR       = 2;
   localparam int unsigned A_TRIG      = 3;
   localparam int unsigned A_LOAD      = 4;
   localparam int unsigned A_CMP_BASE  = 8;
   localparam int unsigned A_MODE_BASE = 16;
   localparam int unsigned TRG_SRC_W   = 3;
   localparam int unsigned TRG_EN_BIT  = 4;
   localparam int unsigned TRG_STP_BIT = 5;
   localparam int unsigned MAX_CMP     = 8;

endpackage

// File: rtl/ctu_counter.sv
module ctu_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] cnt_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (load_i) begin
         cnt_o <= load_val_i;
      end else if (run_i) begin
         cnt_o <= cnt_o + 1'b1;
      end
   end

endmodule

// File: rtl/ctu_slot.sv
module ctu_slot
   import ctu_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter bit          HAS_PIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              run_i,
   input  logic              cmp_we_i,
   input  logic [CNT_W-1:0]  cmp_wdata_i,
   input  logic              mode_we_i,
   input  logic [MODE_W-1:0] mode_wdata_i,
   input  logic              clr_i,
   output logic              match_o,
   output logic              flag_o,
   output logic              pin_o
);

   logic [CNT_W-1:0] cmp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '1;
      end else if (cmp_we_i) begin
         cmp_q <= cmp_wdata_i;
      end
   end

   assign match_o = run_i && (cnt_i == cmp_q);

   // a match wins over a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
      end else begin
         flag_o <= (flag_o && !clr_i) || match_o;
      end
   end

   generate
      if (HAS_PIN) begin : g_pin
         ctu_mode_t mode_q;
         logic      level_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mode_q <= '0;
            end else if (mode_we_i) begin
               mode_q <= ctu_mode_t'(mode_wdata_i);
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               level_q <= 1'b0;
            end else if (match_o) begin
               case (mode_q.act)
                  ACT_LOW:    level_q <= 1'b0;
                  ACT_HIGH:   level_q <= 1'b1;
                  ACT_TOGGLE: level_q <= ~level_q;
                  default:    level_q <= level_q;
               endcase
            end
         end

         assign pin_o = mode_q.sw_sel ? mode_q.sw_lvl : level_q;
      end else begin : g_nopin
         logic unused_mode;
         assign unused_mode = ^{mode_we_i, mode_wdata_i};
         assign pin_o       = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/ctu_trigger.sv
module ctu_trigger #(
   parameter int unsigned NUM_CMP = 6,
   parameter int unsigned SRC_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CMP-1:0] match_i,
   input  logic [SRC_W-1:0]   src_i,
   input  logic               en_i,
   input  logic               stop_i,
   output logic               start_o,
   output logic               stop_o
);

   logic src_hit;

   always_comb begin
      src_hit = 1'b0;
      for (int k = 0; k < NUM_CMP; k++) begin
         if (src_i == SRC_W'(k)) begin
            src_hit = match_i[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_o <= 1'b0;
         stop_o  <= 1'b0;
      end else begin
         start_o <= en_i && src_hit && !stop_i;
         stop_o  <= en_i && src_hit && stop_i;
      end
   end

endmodule

// File: rtl/cmp_timer_unit.sv
module cmp_timer_unit
   import ctu_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned NUM_CMP  = 6,
   parameter int unsigned NUM_PINS = 4,
   parameter int unsigned ADDR_W   = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [CNT_W-1:0]    wr_data,
   output logic [CNT_W-1:0]    count_o,
   output logic [NUM_CMP-1:0]  flags_o,
   output logic [NUM_PINS-1:0] pins_o,
   output logic                irq_o,
   output logic                trig_start_o,
   output logic                trig_stop_o
);

   localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
   localparam logic [ADDR_W-1:0] AD_IEN  = ADDR_W'(A_IEN);
   localparam logic [ADDR_W-1:0] AD_CLR  = ADDR_W'(A_CLR);
   localparam logic [ADDR_W-1:0] AD_TRIG = ADDR_W'(A_TRIG);
   localparam logic [ADDR_W-1:0] AD_LOAD = ADDR_W'(A_LOAD);

   generate
      if (NUM_PINS > NUM_CMP) begin : g_bad_pins
         $error("NUM_PINS must not exceed NUM_CMP");
      end
      if (NUM_CMP > MAX_CMP || NUM_CMP < 1) begin : g_bad_cmp
         $error("NUM_CMP must be 1..MAX_CMP");
      end
      if (CNT_W < 8) begin : g_bad_w
         $error("CNT_W must be at least 8");
      end
      if (ADDR_W < 5) begin : g_bad_a
         $error("ADDR_W must be at least 5");
      end
   endgenerate

   logic                 run_q;
   logic [NUM_CMP-1:0]   ien_q;
   logic [TRG_SRC_W-1:0] trg_src_q;
   logic                 trg_en_q;
   logic                 trg_stop_q;
   logic [NUM_CMP-1:0]   clr_vec;
   logic [NUM_CMP-1:0]   match_vec;
   logic                 load_now;

   assign load_now = wr_en && (wr_addr == AD_LOAD);
   assign clr_vec  = (wr_en && (wr_addr == AD_CLR)) ? wr_data[NUM_CMP-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q      <= 1'b0;
         ien_q      <= '0;
         trg_src_q  <= '0;
         trg_en_q   <= 1'b0;
         trg_stop_q <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == AD_CTRL) begin
            run_q <= wr_data[0];
         end
         if (wr_addr == AD_IEN) begin
            ien_q <= wr_data[NUM_CMP-1:0];
         end
         if (wr_addr == AD_TRIG) begin
            trg_src_q  <= wr_data[TRG_SRC_W-1:0];
            trg_en_q   <= wr_data[TRG_EN_BIT];
            trg_stop_q <= wr_data[TRG_STP_BIT];
         end
      end
   end

   ctu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run_q),
      .load_i     (load_now),
      .load_val_i (wr_data),
      .cnt_o      (count_o)
   );

   generate
      for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
         localparam logic [ADDR_W-1:0] AD_CMP  = ADDR_W'(A_CMP_BASE + i);
         localparam logic [ADDR_W-1:0] AD_MODE = ADDR_W'(A_MODE_BASE + i);
         logic cmp_we;
         logic mode_we;
         assign cmp_we  = wr_en && (wr_addr == AD_CMP);
         assign mode_we = wr_en && (wr_addr == AD_MODE);

         if (i < NUM_PINS) begin : g_pinned
            ctu_slot #(.CNT_W(CNT_W), .HAS_PIN(1'b1)) u_slot (
               .clk          (clk),
               .rst_n        (rst_n),
               .cnt_i        (count_o),
               .run_i        (run_q),
               .cmp_we_i     (cmp_we),
               .cmp_wdata_i  (wr_data),
               .mode_we_i    (mode_we),
               .mode_wdata_i (wr_data[MODE_W-1:0]),
               .clr_i        (clr_vec[i]),
               .match_o      (match_vec[i]),
               .flag_o       (flags_o[i]),
               .pin_o        (pins_o[i])
            );
         end else begin : g_pinless
            logic unused_pin;
            ctu_slot #(.CNT_W(CNT_W), .HAS_PIN(1'b0)) u_slot (
               .clk          (clk),
               .rst_n        (rst_n),
               .cnt_i        (count_o),
               .run_i        (run_q),
               .cmp_we_i     (cmp_we),
               .cmp_wdata_i  (wr_data),
               .mode_we_i    (mode_we),
               .mode_wdata_i (wr_data[MODE_W-1:0]),
               .clr_i        (clr_vec[i]),
               .match_o      (match_vec[i]),
               .flag_o       (flags_o[i]),
               .pin_o        (unused_pin)
            );
         end
      end
   endgenerate

   assign irq_o = |(flags_o & ien_q);

   ctu_trigger #(.NUM_CMP(NUM_CMP), .SRC_W(TRG_SRC_W)) u_trg (
      .clk     (clk),
      .rst_n   (rst_n),
      .match_i (match_vec),
      .src_i   (trg_src_q),
      .en_i    (trg_en_q),
      .stop_i  (trg_stop_q),
      .start_o (trig_start_o),
      .stop_o  (trig_stop_o)
   );

endmodule

// File: rtl/ctu_checker.sv
module ctu_checker
   import ctu_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned NUM_CMP = 6,
   parameter int unsigned ADDR_W  = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [CNT_W-1:0]   wr_data,
   input logic [CNT_W-1:0]   count_o,
   input logic [NUM_CMP-1:0] flags_o,
   input logic               irq_o,
   input logic               trig_start_o,
   input logic               trig_stop_o,
   input logic               run_i
);

   logic [NUM_CMP-1:0] clr_mask;
   logic               load_seen;

   assign clr_mask  = (wr_en && wr_addr == ADDR_W'(A_CLR)) ? wr_data[NUM_CMP-1:0] : '0;
   assign load_seen = wr_en && (wr_addr == ADDR_W'(A_LOAD));

   // R2: stopped counter holds
   a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !load_seen) |=> $stable(count_o));

   // R2: running counter steps by one
   a_r2_step_running: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !load_seen) |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

   // R4: a set flag only drops after a clear write for that bit
   a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(flags_o) & ~$past(clr_mask)) & ~flags_o) == '0));

   // R5: no interrupt without a flag
   a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (flags_o != '0));

   // R9: start and stop never together
   a_r9_trig_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(trig_start_o && trig_stop_o));

   // R9: a trigger pulse comes with a flag set on the same edge
   a_r9_trig_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_start_o || trig_stop_o) |-> (flags_o != '0));

endmodule

bind cmp_timer_unit ctu_checker #(
   .CNT_W   (CNT_W),
   .NUM_CMP (NUM_CMP),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_addr      (wr_addr),
   .wr_data      (wr_data),
   .count_o      (count_o),
   .flags_o      (flags_o),
   .irq_o        (irq_o),
   .trig_start_o (trig_start_o),
   .trig_stop_o  (trig_stop_o),
   .run_i        (run_q)
);

// File: tb/cmp_timer_unit_tb_top.sv
`timescale 1ns/1ps
module cmp_timer_unit_tb_top;

   localparam int CW = 16;
   localparam int NC = 6;
   localparam int NP = 4;
   localparam int AW = 5;

   localparam int R_CTRL = 0, R_IEN = 1, R_CLR = 2, R_TRIG = 3, R_LOAD = 4;
   localparam int R_CMP = 8, R_MODE = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [CW-1:0] count_o;
   logic [NC-1:0] flags_o;
   logic [NP-1:0] pins_o;
   logic          irq_o;
   logic          trig_start_o;
   logic          trig_stop_o;

   int tests_run = 0;
   int tests_failed = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   cmp_timer_unit #(.CNT_W(CW), .NUM_CMP(NC), .NUM_PINS(NP), .ADDR_W(AW)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .count_o      (count_o),
      .flags_o      (flags_o),
      .pins_o       (pins_o),
      .irq_o        (irq_o),
      .trig_start_o (trig_start_o),
      .trig_stop_o  (trig_stop_o)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         tests_run++;
         tests_failed++;
         $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
         $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests_run++;
      if (act !== exp) begin
         tests_failed++;
         $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
      end
   endtask

   // called at a negedge; write lands on the next posedge; returns at the following negedge
   task automatic wr(input int a, input int d);
      wr_en   = 1'b1;
      wr_addr = AW'(a);
      wr_data = CW'(d);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wait_count(input int v);
      int n = 0;
      while (count_o != CW'(v) && n < 2000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 2000) chk("wait_count", 32'(count_o), 32'(v));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wr_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 count", 32'(count_o), 0);
      chk("R1 flags", 32'(flags_o), 0);
      chk("R1 pins", 32'(pins_o), 0);
      chk("R1 irq", 32'(irq_o), 0);
      chk("R1 trig", 32'({trig_start_o, trig_stop_o}), 0);
   endtask

   task automatic t_count();
      do_reset();
      wr(R_CTRL, 1);
      chk("R2 first edge after run", 32'(count_o), 0);
      repeat (5) step();
      chk("R2 counting", 32'(count_o), 5);
      wr(R_CTRL, 0);
      chk("R2 last step on stop", 32'(count_o), 6);
      repeat (3) step();
      chk("R2 hold", 32'(count_o), 6);
      wr(R_LOAD, 100);
      chk("R2 load", 32'(count_o), 100);
      step();
      chk("R2 hold after load", 32'(count_o), 100);
      chk("R1 no flag at all-ones compare", 32'(flags_o), 0);
   endtask

   task automatic t_actions();
      do_reset();
      wr(R_CMP + 0, 14); wr(R_MODE + 0, 2);   // drive 1
      wr(R_CMP + 1, 14); wr(R_MODE + 1, 3);   // toggle
      wr(R_CMP + 2, 14); wr(R_MODE + 2, 0);   // keep
      wr(R_CMP + 3, 16); wr(R_MODE + 3, 2);   // drive 1
      wr(R_LOAD, 10);
      wr(R_CTRL, 1);
      wait_count(14);
      chk("R3 flag not before edge", 32'(flags_o), 0);
      chk("R6 pins not before edge", 32'(pins_o), 0);
      step();
      chk("R3 flags on match", 32'(flags_o), 32'h07);
      chk("R6 drive1/toggle/keep", 32'(pins_o), 32'h3);
      wait_count(16);
      step();
      chk("R3 flag3", 32'(flags_o), 32'h0F);
      chk("R6 pin3 high", 32'(pins_o), 32'hB);
      wr(R_MODE + 3, 1);                      // drive 0
      wr(R_CMP + 3, 30);
      wait_count(30);
      step();
      chk("R6 drive0", 32'(pins_o), 32'h3);
      wr(R_CMP + 1, 33);
      wait_count(33);
      step();
      chk("R6 toggle back", 32'(pins_o), 32'h1);
   endtask

   task automatic t_irq_pinless();
      do_reset();
      wr(R_IEN, 32'h10);
      wr(R_CMP + 4, 5);
      wr(R_CMP + 5, 7);
      wr(R_CTRL, 1);
      wait_count(5);
      chk("R5 irq idle", 32'(irq_o), 0);
      step();
      chk("R7 pinless flag4", 32'(flags_o), 32'h10);
      chk("R5 irq on enabled flag", 32'(irq_o), 1);
      wait_count(7);
      step();
      chk("R7 pinless flag5", 32'(flags_o), 32'h30);
      chk("R7 no pin moved", 32'(pins_o), 0);
      wr(R_CLR, 32'h10);
      chk("R4 clear bit4", 32'(flags_o), 32'h20);
      chk("R5 masked flag no irq", 32'(irq_o), 0);
      wr(R_IEN, 32'h30);
      chk("R5 enable raises irq", 32'(irq_o), 1);
   endtask

   task automatic t_clear_race();
      do_reset();
      wr(R_CMP + 0, 8);
      wr(R_CTRL, 1);
      wait_count(8);
      step();
      chk("R3 flag0", 32'(flags_o), 32'h01);
      wr(R_CLR, 32'h3E);
      chk("R4 zero bits ignored", 32'(flags_o), 32'h01);
      wr(R_LOAD, 6);
      chk("R2 load while running", 32'(count_o), 6);
      wait_count(8);
      wr(R_CLR, 32'h01);
      chk("R4 match beats clear", 32'(flags_o), 32'h01);
      wr(R_CLR, 32'h01);
      chk("R4 clear", 32'(flags_o), 32'h00);
   endtask

   task automatic t_swpin();
      do_reset();
      wr(R_MODE + 0, 32'b0111);               // software pin low, toggle
      wr(R_CMP + 0, 4);
      wr(R_CTRL, 1);
      wait_count(4);
      step();
      chk("R8 flag in software mode", 32'(flags_o), 32'h01);
      chk("R8 pin held low", 32'(pins_o), 0);
      wr(R_MODE + 0, 32'b1111);
      chk("R8 pin shows level", 32'(pins_o), 32'h1);
      wr(R_MODE + 0, 32'b1011);               // hand back, level bit set but unused
      chk("R8 hidden level kept", 32'(pins_o), 32'h1);
   endtask

   task automatic t_trigger();
      do_reset();
      wr(R_TRIG, 32'h12);                     // src 2, enable, start
      wr(R_CMP + 2, 9);
      wr(R_CMP + 1, 7);
      wr(R_CTRL, 1);
      wait_count(7);
      step();
      chk("R9 other source no pulse", 32'({trig_start_o, trig_stop_o}), 0);
      wait_count(9);
      chk("R9 no early pulse", 32'({trig_start_o, trig_stop_o}), 0);
      step();
      chk("R9 start pulse", 32'({trig_start_o, trig_stop_o}), 32'b10);
      step();
      chk("R9 single cycle", 32'({trig_start_o, trig_stop_o}), 0);
      wr(R_TRIG, 32'h35);                     // src 5, enable, stop
      wr(R_CMP + 5, 14);
      wait_count(14);
      step();
      chk("R9 stop pulse", 32'({trig_start_o, trig_stop_o}), 32'b01);
      step();
      chk("R9 stop single", 32'({trig_start_o, trig_stop_o}), 0);
      wr(R_TRIG, 32'h02);                     // disabled
      wr(R_CMP + 2, 20);
      wait_count(20);
      step();
      chk("R9 disabled no pulse", 32'({trig_start_o, trig_stop_o}), 0);
      chk("R9 flag still set", 32'(flags_o[2]), 1);
   endtask

   initial begin
      t_reset();
      t_count();
      t_actions();
      t_irq_pinless();
      t_clear_race();
      t_swpin();
      t_trigger();
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

endmodule